// File: doc/BRIEF.md
# Charge-Path Protection Sequencer

This block drives the charge-enable output of a two-cell lithium-ion pack protector. It takes comparator results that are already digital: one flag per cell for the overcharge threshold, two per-cell release flags (a lower level and a higher level), a load-present flag, an excessive-charger-voltage flag, and the current discharge-enable state from the discharge sequencer. From these it runs two timed fault sequences, cell overcharge and excessive charger voltage, and clears charge-enable while either one is latched. All delays are counted in pulses of a shared time-base tick, so the block has no analog timing and no clock-rate dependence beyond the tick period.

Overcharge release picks its threshold by what is attached. With a charger present the cells must drop to the lower release level. With a load present the higher level is used, so a loaded pack returns to charging without waiting out the full comparator hysteresis. The excessive-charger sequence is held off while the discharge path is open and while an overcharge fault is still latched. A zero-volt charge flag overrides everything and holds charge-enable high so that a fully depleted pack can be revived. A fast-test pin divides every tick count by a fixed factor.

Top module: `chg_path_guard`

## Requirements
- R1: When any cell overcharge flag stays high for OC_DET_TK consecutive ticks, charge-enable goes low on the clock edge of the last of those ticks.
- R2: If every overcharge flag drops before that count is reached, the count restarts from zero, and likewise for every other delay in the block.
- R3: With load_seen low, overcharge release requires every bit of cell_rel_lo to be high (bit i set means cell i is at or below the lower release level); cell_rel_hi is ignored.
- R4: With load_seen high, overcharge release requires every bit of cell_rel_hi to be high; cell_rel_lo is ignored.
- R5: Charge-enable returns high after the release condition has held for OC_REL_TK consecutive ticks.
- R6: When hv_chg stays high for XC_DET_TK consecutive ticks while detection is armed, charge-enable goes low; a drop of hv_chg before then abandons detection and clears the count.
- R7: After an excessive-charger fault, charge-enable returns high once hv_chg has stayed low for XC_REL_TK consecutive ticks.
- R8: Excessive-charger detection is disarmed while dsg_on is low; no ticks are counted toward it in that state.
- R9: Excessive-charger detection is disarmed while an overcharge fault is latched, and its count starts only after the overcharge release has completed.
- R10: While zv_chg is high, chg_en is high regardless of any latched fault; the faults themselves keep running underneath.
- R11: With fast_test high, each delay becomes its nominal count divided by TEST_DIV (integer division), with a floor of one tick.
- R12: Reset leaves chg_en high, both faults clear and all counts at zero; a count interrupted by reset does not carry over.
- R13: Only clock cycles with tick high advance a delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time-base pulse that advances the delay counts |
| cell_ovc | input | NCELL | Per-cell flag: cell at or above the overcharge threshold |
| cell_rel_lo | input | NCELL | Per-cell flag: cell at or below the lower release level |
| cell_rel_hi | input | NCELL | Per-cell flag: cell at or below the higher release level |
| load_seen | input | 1 | A load, not a charger, is attached to the pack |
| hv_chg | input | 1 | Charger voltage beyond the excessive-charger limit |
| dsg_on | input | 1 | Discharge path currently enabled by the discharge sequencer |
| zv_chg | input | 1 | Zero-volt charge request; forces charge-enable high |
| fast_test | input | 1 | Shortened-delay test mode |
| chg_en | output | 1 | Charge path enable, high to allow charging |

## Verification
The hardest situation to reach is an excessive-charger condition that is present the whole time an overcharge fault is being released: the detection count must stay at zero throughout the release and begin only on the tick after it completes. The stimulus trips the overcharge fault, raises hv_chg with the release flags still low for many ticks, then satisfies release and counts the exact number of further ticks before charge-enable drops. A similar gap is opened for the discharge path by holding hv_chg high with dsg_on low, and a reset is issued in the middle of an overcharge count to show that the count restarts.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;

  typedef enum logic { OC_NORMAL = 1'b0, OC_LATCHED = 1'b1 } oc_state_t;
  typedef enum logic { XC_IDLE   = 1'b0, XC_LATCHED = 1'b1 } xc_state_t;

  // Tick count to use for one delay: nominal, or divided in fast-test mode.
  function automatic int unsigned eff_ticks(input int unsigned nominal,
                                            input logic        fast,
                                            input int unsigned divisor);
    int unsigned q;
    q = nominal / divisor;
    if (!fast) return nominal;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/chg_dly_timer.sv
module chg_dly_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          fire
);

  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  // A lowered limit (fast test) still terminates because of the >= compare.
  assign fire    = run && tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || fire) cnt <= '0;
    else if (tick)         cnt <= cnt_inc[CW-1:0];
  end

  assert_hold_without_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  assert_restart_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt == '0));

  assert_cleared_after_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == '0));

endmodule

// File: rtl/chg_ovc_seq.sv
module chg_ovc_seq
  import chg_guard_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          any_over,
  input  logic          release_ok,
  input  logic [CW-1:0] det_lim,
  input  logic [CW-1:0] rel_lim,
  output logic          oc_latched
);

  oc_state_t     st;
  logic          run;
  logic [CW-1:0] lim;
  logic          fire;

  assign run = (st == OC_NORMAL) ? any_over : release_ok;
  assign lim = (st == OC_NORMAL) ? det_lim  : rel_lim;

  chg_dly_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(run), .limit(lim), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= OC_NORMAL;
    else if (fire) st <= (st == OC_NORMAL) ? OC_LATCHED : OC_NORMAL;
  end

  assign oc_latched = (st == OC_LATCHED);

  assert_trip_needs_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_latched) |-> $past(any_over && tick));

  assert_release_needs_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_latched) |-> $past(release_ok && tick));

endmodule

// File: rtl/chg_xc_seq.sv
module chg_xc_seq
  import chg_guard_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hv_seen,
  input  logic          armed,
  input  logic [CW-1:0] det_lim,
  input  logic [CW-1:0] rel_lim,
  output logic          xc_latched
);

  xc_state_t     st;
  logic          run;
  logic [CW-1:0] lim;
  logic          fire;

  assign run = (st == XC_IDLE) ? (hv_seen && armed) : !hv_seen;
  assign lim = (st == XC_IDLE) ? det_lim : rel_lim;

  chg_dly_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .run(run), .limit(lim), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= XC_IDLE;
    else if (fire) st <= (st == XC_IDLE) ? XC_LATCHED : XC_IDLE;
  end

  assign xc_latched = (st == XC_LATCHED);

  assert_trip_needs_hv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xc_latched) |-> $past(hv_seen && armed));

  assert_return_needs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xc_latched) |-> $past(!hv_seen));

endmodule

// File: rtl/chg_path_guard.sv
module chg_path_guard
  import chg_guard_pkg::*;
#(
  parameter int unsigned NCELL     = 2,
  parameter int unsigned OC_DET_TK = 2000,
  parameter int unsigned OC_REL_TK = 80,
  parameter int unsigned XC_DET_TK = 3,
  parameter int unsigned XC_REL_TK = 3,
  parameter int unsigned TEST_DIV  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NCELL-1:0] cell_ovc,
  input  logic [NCELL-1:0] cell_rel_lo,
  input  logic [NCELL-1:0] cell_rel_hi,
  input  logic             load_seen,
  input  logic             hv_chg,
  input  logic             dsg_on,
  input  logic             zv_chg,
  input  logic             fast_test,
  output logic             chg_en
);

  localparam int unsigned MAXTK = max_of4(OC_DET_TK, OC_REL_TK, XC_DET_TK, XC_REL_TK);
  localparam int unsigned CW    = $clog2(MAXTK + 1);

  logic [CW-1:0]    oc_det_lim, oc_rel_lim, xc_det_lim, xc_rel_lim;
  logic [NCELL-1:0] cell_released;
  logic             any_over, release_ok, xc_armed;
  logic             oc_latched, xc_latched;

  assign oc_det_lim = CW'(eff_ticks(OC_DET_TK, fast_test, TEST_DIV));
  assign oc_rel_lim = CW'(eff_ticks(OC_REL_TK, fast_test, TEST_DIV));
  assign xc_det_lim = CW'(eff_ticks(XC_DET_TK, fast_test, TEST_DIV));
  assign xc_rel_lim = CW'(eff_ticks(XC_REL_TK, fast_test, TEST_DIV));

  // Per cell: pick the release level that matches what is attached.
  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    assign cell_released[c] = load_seen ? cell_rel_hi[c] : cell_rel_lo[c];
  end

  assign any_over   = |cell_ovc;
  assign release_ok = &cell_released;
  assign xc_armed   = dsg_on && !oc_latched;

  chg_ovc_seq #(.CW(CW)) u_ovc (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .any_over(any_over), .release_ok(release_ok),
    .det_lim(oc_det_lim), .rel_lim(oc_rel_lim),
    .oc_latched(oc_latched)
  );

  chg_xc_seq #(.CW(CW)) u_xc (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hv_seen(hv_chg), .armed(xc_armed),
    .det_lim(xc_det_lim), .rel_lim(xc_rel_lim),
    .xc_latched(xc_latched)
  );

  assign chg_en = zv_chg || !(oc_latched || xc_latched);

  assert_xc_needs_dsg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xc_latched) |-> $past(dsg_on));

  assert_xc_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xc_latched) |-> $past(!oc_latched));

  assert_release_threshold_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_latched) |-> $past(load_seen ? (&cell_rel_hi) : (&cell_rel_lo)));

  assert_low_only_on_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_en) |-> (!zv_chg && (oc_latched || xc_latched)));

endmodule

// File: tb/test_chg_path_guard.sv
module test_chg_path_guard;

  localparam int unsigned D1  = 20;
  localparam int unsigned D2  = 6;
  localparam int unsigned D5  = 3;
  localparam int unsigned D6  = 3;
  localparam int unsigned DIV = 4;

  // Fast-test counts worked out from R11: nominal/DIV, never below one.
  function automatic int unsigned fast_of(input int unsigned n);
    return (n / DIV == 0) ? 1 : n / DIV;
  endfunction
  localparam int unsigned F1 = fast_of(D1);
  localparam int unsigned F2 = fast_of(D2);
  localparam int unsigned F5 = fast_of(D5);
  localparam int unsigned F6 = fast_of(D6);

  typedef struct packed {
    logic [1:0] ovc;
    logic [1:0] rlo;
    logic [1:0] rhi;
    logic       load;
    logic       xc;
    logic       dsg;
    logic       zv;
    logic       tst;
    logic [7:0] nt;
    logic       exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D1-1), 1'b1, 8'd1},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,     1'b1, 8'd2},
    '{2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D1-1), 1'b1, 8'd2},
    '{2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,     1'b0, 8'd1},
    '{2'b00, 2'b01, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd10,    1'b0, 8'd3},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D2-1), 1'b0, 8'd5},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,     1'b1, 8'd3},
    '{2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D1),   1'b0, 8'd1},
    '{2'b00, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd10,    1'b0, 8'd4},
    '{2'b00, 2'b00, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D2),   1'b1, 8'd4},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd10,    1'b1, 8'd8},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'(D5-1), 1'b1, 8'd6},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,     1'b1, 8'd6},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'(D5-1), 1'b1, 8'd6},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1,     1'b0, 8'd6},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D6-1), 1'b0, 8'd7},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1,     1'b1, 8'd7},
    '{2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'(D1),   1'b1, 8'd10},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0,     1'b0, 8'd10},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D2),   1'b1, 8'd3},
    '{2'b11, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D1),   1'b0, 8'd1},
    '{2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd10,    1'b0, 8'd9},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'(D2),   1'b1, 8'd9},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'(D5-1), 1'b1, 8'd9},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1,     1'b0, 8'd9},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(D6),   1'b1, 8'd7},
    '{2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'(F1-1), 1'b1, 8'd11},
    '{2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd1,     1'b0, 8'd11},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'(F2),   1'b1, 8'd11},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'(F5),   1'b0, 8'd11},
    '{2'b00, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'(F6),   1'b1, 8'd11}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] cell_ovc = '0, cell_rel_lo = '0, cell_rel_hi = '0;
  logic       load_seen = 1'b0, hv_chg = 1'b0, dsg_on = 1'b1;
  logic       zv_chg = 1'b0, fast_test = 1'b0;
  logic       chg_en;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  chg_path_guard #(
    .NCELL(2), .OC_DET_TK(D1), .OC_REL_TK(D2),
    .XC_DET_TK(D5), .XC_REL_TK(D6), .TEST_DIV(DIV)
  ) i_chg_path_guard (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cell_ovc(cell_ovc), .cell_rel_lo(cell_rel_lo), .cell_rel_hi(cell_rel_hi),
    .load_seen(load_seen), .hv_chg(hv_chg), .dsg_on(dsg_on),
    .zv_chg(zv_chg), .fast_test(fast_test), .chg_en(chg_en)
  );

  task automatic check(input logic exp, input string req);
    #1;
    checks++;
    if (chg_en !== exp) begin
      errors++;
      $display("FAIL %s: chg_en actual=%b expected=%b at %0t", req, chg_en, exp, $time);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b1, "R12 reset state");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cell_ovc    = TBL[i].ovc;
      cell_rel_lo = TBL[i].rlo;
      cell_rel_hi = TBL[i].rhi;
      load_seen   = TBL[i].load;
      hv_chg      = TBL[i].xc;
      dsg_on      = TBL[i].dsg;
      zv_chg      = TBL[i].zv;
      fast_test   = TBL[i].tst;
      pulse_ticks(int'(TBL[i].nt));
      check(TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // R13: overcharge flag held through many cycles with no tick
    @(negedge clk);
    fast_test = 1'b0; hv_chg = 1'b0; cell_rel_lo = '0; cell_ovc = 2'b11;
    repeat (3 * D1) @(negedge clk);
    check(1'b1, "R13 no tick no count");

    // R12: reset in the middle of an overcharge count
    pulse_ticks(D1 - 1);
    check(1'b1, "R12 partial count");
    do_reset();
    check(1'b1, "R12 after reset");
    pulse_ticks(D1 - 1);
    check(1'b1, "R12 count restarted");
    pulse_ticks(1);
    check(1'b0, "R1 trip after full count");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule